// File: doc/BRIEF.md
# Audio Slot Sample Buffer

This block is a small sample buffer for one audio stream. It sits between a DMA request/acknowledge handshake and the engine that fills and empties the time slots of a serial audio link. A parameter fixes the direction at build time.

In transmit form, DMA acknowledges write words into the buffer and link-side requests take them out. In receive form, link-side strobes write words in and DMA acknowledges take them out. The buffer raises the DMA request line when there is work to do. It returns a per-word valid flag to the link side. It keeps sticky underrun and overrun bits. With the halt option set, it stops requesting DMA after an error until the stream is switched off.

A transmit buffer answers link requests with no data until it has been filled once after enable. This holds back samples until the buffer is full. It follows that a DMA transfer must be at least as long as the depth. The depth is a parameter: 3 for stereo PCM and surround, 2 for center and LFE, and 1 for a modem line. Switching the stream off and on again is the recovery step.

Top module: `audio_slot_fifo`

## Requirements
- R1: Transmit form: `dma_req` is high exactly when `en` is 1, the halt state is clear and the buffer holds fewer than DEPTH words.
- R2: Transmit form: after enable, every link request gets `link_valid`=0 and `link_rdata`=0, with no underrun, until the buffer has been full for one cycle.
- R3: Transmit form, once primed: a link request (`link_stb` high for one cycle) with the buffer non-empty makes `link_valid`=1 and `link_rdata`=oldest word from the next cycle on. These values hold until the next request.
- R4: Transmit form, once primed: a link request with the buffer empty makes `link_valid`=0 and `link_rdata`=0 and sets `underrun`.
- R5: Receive form: `dma_req` is high exactly when `en` is 1, the halt state is clear and the buffer is non-empty. While it is high, `dma_rdata` shows the oldest word, and `dma_ack` removes that word.
- R6: Receive form: a link strobe while `en`=0 stores nothing.
- R7: Receive form: a link strobe while the buffer is full drops the word, leaves the contents unchanged and sets `overrun`.
- R8: With `halt_en`=1, an underrun or overrun event forces `dma_req` low from the next cycle. It stays low until `en` goes to 0.
- R9: `en`=0 empties the buffer, clears the halt state and the transmit primed state, and drives `link_valid`/`link_rdata` to 0. `underrun` and `overrun` keep their values.
- R10: An `err_clr` pulse clears `underrun` and `overrun` on the next edge. A new error event in the same cycle wins and keeps the bit set.
- R11: A write and a read in the same cycle leave the occupancy unchanged and keep word order.
- R12: A DMA acknowledge while the transmit buffer is full, or while `en`=0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Stream enable |
| halt_en | input | 1 | Stop DMA requests after an error |
| err_clr | input | 1 | Pulse that clears the sticky error bits |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge (write in transmit form, read in receive form) |
| dma_wdata | input | W | DMA write word (transmit form) |
| dma_rdata | output | W | Oldest word for DMA (receive form) |
| link_stb | input | 1 | Link request (transmit) or data strobe (receive) |
| link_wdata | input | W | Link word to store (receive form) |
| link_valid | output | 1 | Slot valid flag for the last request (transmit form) |
| link_rdata | output | W | Slot word for the last request (transmit form) |
| underrun | output | 1 | Sticky underrun bit |
| overrun | output | 1 | Sticky overrun bit |

## Verification
The assertions check the following on every cycle:
- the occupancy bound;
- the absence of a transmit request when the buffer is full;
- the receive request while data is waiting;
- the held-low request during halt;
- the flush on disable;
- the single-step change of occupancy;
- the blank slot before priming.

Word order, the prefill-then-release sequence, the drop of a word on overrun, and how sticky bits interact with clear pulses and recovery are shown only by the bench scenarios. The bench checks these against a queue model over directed and random traffic.

// File: rtl/audio_slot_fifo.sv
`timescale 1ns/1ps
module audio_slot_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 3,
  parameter bit IS_TX = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         halt_en,
  input  logic         err_clr,
  output logic         dma_req,
  input  logic         dma_ack,
  input  logic [W-1:0] dma_wdata,
  output logic [W-1:0] dma_rdata,
  input  logic         link_stb,
  input  logic [W-1:0] link_wdata,
  output logic         link_valid,
  output logic [W-1:0] link_rdata,
  output logic         underrun,
  output logic         overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          primed, halted;

  wire full  = (count == CW'(DEPTH));
  wire empty = (count == '0);

  wire push = en & !full & (IS_TX ? dma_ack : link_stb);
  wire pop  = en & !empty & (IS_TX ? (link_stb & primed) : dma_ack);
  wire under_ev = IS_TX & en & link_stb & primed & empty;
  wire over_ev  = !IS_TX & en & link_stb & full;
  wire [W-1:0] push_data = IS_TX ? dma_wdata : link_wdata;
  wire [W-1:0] head = mem[rptr];

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dma_req   = en & !halted & (IS_TX ? !full : !empty);
  assign dma_rdata = IS_TX ? '0 : head;

  always_ff @(posedge clk)
    if (push) mem[wptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; primed <= 1'b0; halted <= 1'b0;
    end else if (!en) begin
      wptr <= '0; rptr <= '0; count <= '0; primed <= 1'b0; halted <= 1'b0;
    end else begin
      if (push) wptr <= adv(wptr);
      if (pop)  rptr <= adv(rptr);
      count  <= count + CW'(push) - CW'(pop);
      primed <= primed | full;
      halted <= halted | (halt_en & (under_ev | over_ev));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0; overrun <= 1'b0;
    end else begin
      underrun <= under_ev | (underrun & !err_clr);
      overrun  <= over_ev  | (overrun  & !err_clr);
    end
  end

  generate
    if (IS_TX) begin : g_tx_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          link_valid <= 1'b0; link_rdata <= '0;
        end else if (!en) begin
          link_valid <= 1'b0; link_rdata <= '0;
        end else if (link_stb) begin
          link_valid <= pop;
          link_rdata <= pop ? head : '0;
        end
      end
    end else begin : g_rx_out
      assign link_valid = 1'b0;
      assign link_rdata = '0;
    end
  endgenerate
endmodule

// File: rtl/audio_slot_fifo_chk.sv
`timescale 1ns/1ps
module audio_slot_fifo_chk #(
  parameter int W     = 20,
  parameter int DEPTH = 3,
  parameter bit IS_TX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dma_req,
  input logic          link_valid,
  input logic [W-1:0]  link_rdata,
  input logic [CW-1:0] count,
  input logic          primed,
  input logic          halted
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_full_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && int'(count) == DEPTH) |-> !dma_req);

  assert_rx_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_TX && en && !halted && count != '0) |-> dma_req);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dma_req);

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && en) |=> halted);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0 && !primed));

  assert_prefill_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && en && !primed) |=> !link_valid);

  assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !link_valid |-> link_rdata == '0);

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (int'(count) - int'($past(count)) <= 1 &&
                           int'($past(count)) - int'(count) <= 1));
endmodule

bind audio_slot_fifo audio_slot_fifo_chk #(.W(W), .DEPTH(DEPTH), .IS_TX(IS_TX)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dma_req(dma_req), .link_valid(link_valid),
  .link_rdata(link_rdata), .count(count), .primed(primed), .halted(halted)
);

// File: tb/audio_slot_fifo_tb.sv
`timescale 1ns/1ps
module audio_slot_fifo_tb;
  localparam int W = 16;
  localparam int DT = 3;
  localparam int DR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic t_en = 0, t_halt = 0, t_clr = 0, t_ack = 0, t_stb = 0;
  logic [W-1:0] t_wd = '0;
  logic t_req, t_lv, t_und, t_ovr;
  logic [W-1:0] t_rd, t_ld;

  logic r_en = 0, r_halt = 0, r_clr = 0, r_ack = 0, r_stb = 0;
  logic [W-1:0] r_wd = '0;
  logic r_req, r_lv, r_und, r_ovr;
  logic [W-1:0] r_rd, r_ld;

  audio_slot_fifo #(.W(W), .DEPTH(DT), .IS_TX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(t_en), .halt_en(t_halt), .err_clr(t_clr),
    .dma_req(t_req), .dma_ack(t_ack), .dma_wdata(t_wd), .dma_rdata(t_rd),
    .link_stb(t_stb), .link_wdata('0), .link_valid(t_lv), .link_rdata(t_ld),
    .underrun(t_und), .overrun(t_ovr));

  audio_slot_fifo #(.W(W), .DEPTH(DR), .IS_TX(1'b0)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .en(r_en), .halt_en(r_halt), .err_clr(r_clr),
    .dma_req(r_req), .dma_ack(r_ack), .dma_wdata('0), .dma_rdata(r_rd),
    .link_stb(r_stb), .link_wdata(r_wd), .link_valid(r_lv), .link_rdata(r_ld),
    .underrun(r_und), .overrun(r_ovr));

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // transmit model
  logic [W-1:0] qt[$];
  bit mt_primed = 0, mt_halt = 0, mt_und = 0, mt_lv = 0;
  logic [W-1:0] mt_ld = '0;

  function automatic bit tx_req_exp(bit e);
    return e & !mt_halt & (qt.size() < DT);
  endfunction

  task automatic step_tx(string tag, bit e, bit h, bit c, bit a, logic [W-1:0] d, bit s);
    bit push, pop, uev, np;
    @(negedge clk);
    t_en = e; t_halt = h; t_clr = c; t_ack = a; t_wd = d; t_stb = s;
    #1;
    chk({tag, " dma_req"}, t_req, tx_req_exp(e));
    push = e & a & (qt.size() < DT);
    pop  = e & s & mt_primed & (qt.size() > 0);
    uev  = e & s & mt_primed & (qt.size() == 0);
    if (!e) begin mt_lv = 0; mt_ld = '0; end
    else if (s) begin mt_lv = pop; mt_ld = pop ? qt[0] : '0; end
    np = e & (mt_primed | (qt.size() == DT));
    mt_halt = e & (mt_halt | (h & uev));
    mt_und = uev | (mt_und & !c);
    if (!e) qt.delete();
    else begin
      if (pop) void'(qt.pop_front());
      if (push) qt.push_back(d);
    end
    mt_primed = np;
    @(posedge clk); #1;
    chk({tag, " link_valid"}, t_lv, mt_lv);
    chk({tag, " link_rdata"}, t_ld, mt_ld);
    chk({tag, " underrun"}, t_und, mt_und);
    chk({tag, " overrun(tx)"}, t_ovr, 0);
  endtask

  // receive model
  logic [W-1:0] qr[$];
  bit mr_halt = 0, mr_ovr = 0;

  task automatic step_rx(string tag, bit e, bit h, bit c, bit a, bit s, logic [W-1:0] d);
    bit push, pop, oev, er;
    @(negedge clk);
    r_en = e; r_halt = h; r_clr = c; r_ack = a; r_stb = s; r_wd = d;
    #1;
    er = e & !mr_halt & (qr.size() > 0);
    chk({tag, " dma_req"}, r_req, er);
    if (qr.size() > 0) chk({tag, " dma_rdata"}, r_rd, qr[0]);
    push = e & s & (qr.size() < DR);
    oev  = e & s & (qr.size() == DR);
    pop  = e & a & (qr.size() > 0);
    mr_halt = e & (mr_halt | (h & oev));
    mr_ovr = oev | (mr_ovr & !c);
    if (!e) qr.delete();
    else begin
      if (pop) void'(qr.pop_front());
      if (push) qr.push_back(d);
    end
    @(posedge clk); #1;
    chk({tag, " overrun"}, r_ovr, mr_ovr);
    chk({tag, " underrun(rx)"}, r_und, 0);
    chk({tag, " link_valid(rx)"}, r_lv, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset tx dma_req", t_req, 0);
    chk("R9 reset link_valid", t_lv, 0);
    chk("R9 reset underrun", t_und, 0);
    chk("R9 reset rx dma_req", r_req, 0);
    chk("R9 reset overrun", r_ovr, 0);
    @(negedge clk); rst_n = 1;

    // transmit directed
    step_tx("R1 enable", 1,0,0,0,'0,0);
    step_tx("R2 prefill request", 1,0,0,0,'0,1);
    step_tx("R1 fill a", 1,0,0,1,16'h1111,1);
    step_tx("R1 fill b", 1,0,0,1,16'h2222,0);
    step_tx("R1 fill c", 1,0,0,1,16'h3333,0);
    step_tx("R12 ack while full", 1,0,0,1,16'hDEAD,0);
    step_tx("R3 first word", 1,0,0,0,'0,1);
    step_tx("R3 hold", 1,0,0,0,'0,0);
    step_tx("R11 write and read", 1,0,0,1,16'h4444,1);
    step_tx("R3 drain", 1,0,0,0,'0,1);
    step_tx("R3 drain last", 1,0,0,0,'0,1);
    step_tx("R4 underrun", 1,0,0,0,'0,1);
    step_tx("R4 sticky", 1,0,0,0,'0,0);
    step_tx("R10 clear with event", 1,0,1,0,'0,1);
    step_tx("R10 clear", 1,0,1,0,'0,0);
    step_tx("R12 ack while off", 0,0,0,1,16'hBEEF,0);
    step_tx("R9 re-enable", 1,1,0,0,'0,1);
    for (int i = 0; i < 3; i++) step_tx("R2 refill", 1,1,0,1,W'(16'h5000 + i),1);
    step_tx("R3 prime", 1,1,0,0,'0,0);
    for (int i = 0; i < 4; i++) step_tx("R8 drain to underrun", 1,1,0,0,'0,1);
    step_tx("R8 halted", 1,1,0,0,'0,0);
    step_tx("R8 still halted", 1,0,0,1,16'h7777,0);
    step_tx("R9 disable keeps error", 0,0,0,0,'0,0);
    step_tx("R9 recovered", 1,0,0,0,'0,0);
    for (int i = 0; i < 1500; i++) begin
      bit e = ($urandom_range(0, 31) != 0);
      step_tx("RND R1 R3 R4 R11", e, $urandom_range(0,3) == 0, $urandom_range(0,15) == 0,
              $urandom_range(0,1), W'($urandom), $urandom_range(0,1));
    end

    // receive directed
    step_rx("R5 enable empty", 1,0,0,0,0,'0);
    step_rx("R5 store a", 1,0,0,0,1,16'hA001);
    step_rx("R5 store b", 1,0,0,0,1,16'hA002);
    step_rx("R7 overrun drop", 1,0,0,0,1,16'hBAD0);
    step_rx("R7 contents kept", 1,0,0,1,0,'0);
    step_rx("R11 strobe and read", 1,0,0,1,1,16'hA003);
    step_rx("R5 read", 1,0,0,1,0,'0);
    step_rx("R10 clear", 1,0,1,0,0,'0);
    step_rx("R6 strobe while off", 0,0,0,0,1,16'hC0DE);
    step_rx("R6 nothing stored", 1,0,0,0,0,'0);
    step_rx("R8 fill", 1,1,0,0,1,16'hD001);
    step_rx("R8 fill", 1,1,0,0,1,16'hD002);
    step_rx("R8 overrun halts", 1,1,0,0,1,16'hD003);
    step_rx("R8 req held low", 1,0,0,0,0,'0);
    step_rx("R9 disable", 0,0,0,0,0,'0);
    step_rx("R9 recovered", 1,0,1,0,0,'0);
    for (int i = 0; i < 1500; i++) begin
      bit e = ($urandom_range(0, 31) != 0);
      step_rx("RND R5 R7 R11", e, $urandom_range(0,3) == 0, $urandom_range(0,15) == 0,
              $urandom_range(0,1), $urandom_range(0,1), W'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule